// File: doc/BRIEF.md
# Polar Block Encoder

This block turns a short message into one polar codeword of length N = 2^n, where n is set when the block is built. A frozen-position mask marks which of the N indices carry message bits and which are forced to zero. The block builds the input vector from the message and the mask, reorders it by reversing the bits of each index, and then applies the n-fold Kronecker power of the 2x2 polarising kernel. All arithmetic is over GF(2).

The transform is pipelined as n butterfly stages of XOR gates, with a register after each stage. The encoder takes a new block on every clock and returns each codeword a fixed n cycles after it was offered. The mask is an input that is applied with each block. The surrounding logic chooses the reliable indices, and the message must fill exactly as many positions as the mask leaves open.

Top module: `polar_encoder`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the next cycle shows `cw_valid_o` low and `cw_o` all zero, even if blocks were in flight.
- R2: `cw_valid_o` in cycle c+n equals `msg_valid_i` in cycle c. Blocks offered on consecutive cycles come out on consecutive cycles, and no output appears without a matching input.
- R3: A mask bit of 1 marks a frozen index, which is set to 0. A mask bit of 0 marks an information index. Message bit j goes to the j-th lowest information index, counting from 0. Every valid mask holds exactly K zeros.
- R4: With u the placed vector, `cw_o` bit c is x_c, where x = u * B_N * F^(Kronecker n) over GF(2). B_N swaps index i with the index whose n-bit binary form is i reversed. F has rows [1 0] and [1 1], and the row-vector convention is used, so x_c is the XOR of v_r over every r whose set bits include all set bits of c.
- R5: `cw_o[0]` of every codeword equals the XOR of all K message bits of its block.
- R6: `cw_o[N-1]` equals message bit K-1 when index N-1 is an information index, and 0 when it is frozen.
- R7: The mask is taken with each block. Consecutive blocks with different masks are each encoded with their own mask.
- R8: The block is correct for any n >= 1 and any K <= N. Both N = 8 with K = 4 and N = 16 with K = 8 meet R2 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| msg_valid_i | input | 1 | A block is offered this cycle |
| msg_i | input | K | Message bits, bit 0 placed first |
| frozen_mask_i | input | N | 1 = frozen index, 0 = information index |
| cw_valid_o | output | 1 | Codeword on `cw_o` is valid |
| cw_o | output | N | Codeword, bit c is x_c |

## Verification
The hardest cases to reach from the ports are a full pipeline whose mask changes on every cycle, and a reset that lands while n blocks are still moving through the stages. The stimulus sends unbroken runs of blocks, each with its own random mask of exactly K zeros, so that every stage holds a different block. Reset is then raised in the middle of such a run, and the bench checks that nothing drains out afterwards. Directed masks put all information bits at the top indices or at the bottom indices. This drives both the highest-index rule and the bit-reversal wiring at their edges.

// File: rtl/polar_pkg.sv
package polar_pkg;

    // Reverse the low 'width' bits of idx.
    function automatic int bit_rev(input int idx, input int width);
        int r;
        r = 0;
        for (int b = 0; b < width; b++) begin
            r = (r << 1) | ((idx >> b) & 1);
        end
        return r;
    endfunction

    // True when butterfly stage 'stage' uses index i as the upper leg of a pair.
    function automatic bit is_upper_leg(input int idx, input int stage);
        return ((idx >> stage) & 1) == 0;
    endfunction

endpackage

// File: rtl/polar_insert.sv
module polar_insert #(
    parameter int LOG2N = 4,
    parameter int K     = 8
) (
    input  logic [K-1:0]            msg_i,
    input  logic [(1<<LOG2N)-1:0]   frozen_mask_i,
    output logic [(1<<LOG2N)-1:0]   v_o
);
    localparam int N = 1 << LOG2N;

    logic [N-1:0]     msg_pad;
    logic [N-1:0]     u_vec;
    logic [LOG2N-1:0] rank;

    always_comb begin
        msg_pad        = '0;
        msg_pad[K-1:0] = msg_i;
    end

    // Fill information indices in ascending order; frozen indices stay zero.
    always_comb begin
        u_vec = '0;
        rank  = '0;
        for (int i = 0; i < N; i++) begin
            if (!frozen_mask_i[i]) begin
                u_vec[i] = msg_pad[rank];
                rank     = rank + 1'b1;
            end
        end
    end

    // Bit-reversal permutation is pure wiring.
    for (genvar j = 0; j < N; j++) begin : g_rev
        localparam int SRC = polar_pkg::bit_rev(j, LOG2N);
        assign v_o[j] = u_vec[SRC];
    end

endmodule

// File: rtl/polar_stage.sv
module polar_stage #(
    parameter int LOG2N = 4,
    parameter int STAGE = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vld_i,
    input  logic [(1<<LOG2N)-1:0]   d_i,
    output logic                    vld_o,
    output logic [(1<<LOG2N)-1:0]   q_o
);
    localparam int N    = 1 << LOG2N;
    localparam int SPAN = 1 << STAGE;

    logic [N-1:0] mix;

    for (genvar i = 0; i < N; i++) begin : g_bf
        if (polar_pkg::is_upper_leg(i, STAGE)) begin : g_xor
            assign mix[i] = d_i[i] ^ d_i[i+SPAN];
        end else begin : g_pass
            assign mix[i] = d_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            q_o   <= '0;
        end else begin
            vld_o <= vld_i;
            q_o   <= mix;
        end
    end

endmodule

// File: rtl/polar_encoder.sv
module polar_encoder #(
    parameter int LOG2N = 4,
    parameter int K     = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    msg_valid_i,
    input  logic [K-1:0]            msg_i,
    input  logic [(1<<LOG2N)-1:0]   frozen_mask_i,
    output logic                    cw_valid_o,
    output logic [(1<<LOG2N)-1:0]   cw_o
);
    localparam int N = 1 << LOG2N;

    logic [N-1:0] data_c [LOG2N+1];
    logic [LOG2N:0] vld_c;

    polar_insert #(.LOG2N(LOG2N), .K(K)) u_insert (
        .msg_i         (msg_i),
        .frozen_mask_i (frozen_mask_i),
        .v_o           (data_c[0])
    );

    assign vld_c[0] = msg_valid_i;

    for (genvar s = 0; s < LOG2N; s++) begin : g_stage
        polar_stage #(.LOG2N(LOG2N), .STAGE(s)) u_stage (
            .clk   (clk),
            .rst   (rst),
            .vld_i (vld_c[s]),
            .d_i   (data_c[s]),
            .vld_o (vld_c[s+1]),
            .q_o   (data_c[s+1])
        );
    end

    assign cw_valid_o = vld_c[LOG2N];
    assign cw_o       = data_c[LOG2N];

endmodule

// File: rtl/polar_encoder_chk.sv
module polar_encoder_chk #(
    parameter int LOG2N = 4,
    parameter int K     = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    msg_valid_i,
    input  logic [K-1:0]            msg_i,
    input  logic [(1<<LOG2N)-1:0]   frozen_mask_i,
    input  logic                    cw_valid_o,
    input  logic [(1<<LOG2N)-1:0]   cw_o
);
    localparam int N = 1 << LOG2N;

    // Independent delay lines of n cycles for valid, parity and top bit.
    logic [LOG2N-1:0] vld_sh;
    logic [LOG2N-1:0] par_sh;
    logic [LOG2N-1:0] top_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_sh <= '0;
            par_sh <= '0;
            top_sh <= '0;
        end else begin
            for (int s = LOG2N - 1; s > 0; s--) begin
                vld_sh[s] <= vld_sh[s-1];
                par_sh[s] <= par_sh[s-1];
                top_sh[s] <= top_sh[s-1];
            end
            vld_sh[0] <= msg_valid_i;
            par_sh[0] <= ^msg_i;
            top_sh[0] <= frozen_mask_i[N-1] ? 1'b0 : msg_i[K-1];
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!cw_valid_o && cw_o == '0)); // R1
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst) cw_valid_o == vld_sh[LOG2N-1]); // R2
    AST_MASK_WEIGHT: assert property (@(posedge clk) disable iff (rst) msg_valid_i |-> ($countones(frozen_mask_i) == N - K)); // R3
    AST_PARITY_BIT: assert property (@(posedge clk) disable iff (rst) cw_valid_o |-> (cw_o[0] == par_sh[LOG2N-1])); // R5
    AST_TOP_BIT: assert property (@(posedge clk) disable iff (rst) cw_valid_o |-> (cw_o[N-1] == top_sh[LOG2N-1])); // R6

endmodule

bind polar_encoder polar_encoder_chk #(.LOG2N(LOG2N), .K(K)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .msg_valid_i   (msg_valid_i),
    .msg_i         (msg_i),
    .frozen_mask_i (frozen_mask_i),
    .cw_valid_o    (cw_valid_o),
    .cw_o          (cw_o)
);

// File: tb/polar_encoder_tb.sv
`timescale 1ns/1ps
module polar_encoder_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    // 16-point instance (n=4, K=8)
    logic        v16 = 1'b0;
    logic [7:0]  m16 = '0;
    logic [15:0] k16 = '1;
    logic        ov16;
    logic [15:0] cw16;
    // 8-point instance (n=3, K=4)
    logic        v8 = 1'b0;
    logic [3:0]  m8 = '0;
    logic [7:0]  k8 = '1;
    logic        ov8;
    logic [7:0]  cw8;

    polar_encoder #(.LOG2N(4), .K(8)) u_dut (
        .clk(clk), .rst(rst), .msg_valid_i(v16), .msg_i(m16),
        .frozen_mask_i(k16), .cw_valid_o(ov16), .cw_o(cw16));

    polar_encoder #(.LOG2N(3), .K(4)) u_dut8 (
        .clk(clk), .rst(rst), .msg_valid_i(v8), .msg_i(m8),
        .frozen_mask_i(k8), .cw_valid_o(ov8), .cw_o(cw8));

    typedef struct {
        logic [15:0] cw;
        logic [15:0] msg;
        logic [15:0] mask;
        int          due;
        string       tag;
    } item_t;

    item_t q16[$];
    item_t q8[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int rev(input int x, input int n);
        int r = 0;
        for (int b = 0; b < n; b++) r = (r << 1) | ((x >> b) & 1);
        return r;
    endfunction

    // Place message bits into information indices (mask bit 0), ascending.
    function automatic logic [15:0] place(input logic [15:0] msg, input logic [15:0] mask, input int n);
        logic [15:0] u = '0;
        int r = 0;
        for (int i = 0; i < (1 << n); i++) begin
            if (!mask[i]) begin
                u[i] = msg[r];
                r++;
            end
        end
        return u;
    endfunction

    // Reference matrix product: x_c = XOR of v_r over all r containing c.
    function automatic logic [15:0] ref_x(input logic [15:0] u, input int n);
        logic [15:0] x = '0;
        int nn = 1 << n;
        for (int c = 0; c < nn; c++) begin
            logic acc = 1'b0;
            for (int r = 0; r < nn; r++) begin
                if ((c & ~r & (nn - 1)) == 0) acc ^= u[rev(r, n)];
            end
            x[c] = acc;
        end
        return x;
    endfunction

    function automatic logic [15:0] rand_mask(input int n, input int k);
        int nn = 1 << n;
        logic [15:0] m = '0;
        int cnt = 0;
        for (int i = 0; i < nn; i++) m[i] = 1'b1;
        while (cnt < k) begin
            int p = int'($urandom % nn);
            if (m[p]) begin
                m[p] = 1'b0;
                cnt++;
            end
        end
        return m;
    endfunction

    task automatic send16(input logic [15:0] msg, input logic [15:0] mask, input string tag);
        item_t it;
        @(negedge clk);
        v16 = 1'b1; m16 = msg[7:0]; k16 = mask;
        it.msg = {8'h00, msg[7:0]}; it.mask = mask; it.due = cyc + 4; it.tag = tag;
        it.cw = ref_x(place(it.msg, mask, 4), 4);
        q16.push_back(it);
    endtask

    task automatic send8(input logic [15:0] msg, input logic [15:0] mask, input string tag);
        item_t it;
        @(negedge clk);
        v8 = 1'b1; m8 = msg[3:0]; k8 = mask[7:0];
        it.msg = {12'h000, msg[3:0]}; it.mask = {8'h00, mask[7:0]}; it.due = cyc + 3; it.tag = tag;
        it.cw = ref_x(place(it.msg, it.mask, 3), 3);
        q8.push_back(it);
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            v16 = 1'b0; v8 = 1'b0;
        end
    endtask

    task automatic chk(ref item_t q[$], input logic vld, input logic [15:0] cw,
                       input int n, input int k, input string nm);
        item_t it;
        int nn;
        logic e7;
        nn = 1 << n;
        if (q.size() > 0 && q[0].due == cyc) begin
            it = q.pop_front();
            checks++;
            if (!vld) begin
                errors++;
                $display("FAIL R2 %s cycle %0d valid got 0 expected 1", nm, cyc);
            end else begin
                checks++;
                if (cw != it.cw) begin
                    errors++;
                    $display("FAIL %s %s codeword got %h expected %h", it.tag, nm, cw, it.cw);
                end
                checks++;
                if (cw[0] != ^it.msg) begin
                    errors++;
                    $display("FAIL R5 %s bit0 got %b expected %b", nm, cw[0], ^it.msg);
                end
                checks++;
                e7 = it.mask[nn-1] ? 1'b0 : it.msg[k-1];
                if (cw[nn-1] != e7) begin
                    errors++;
                    $display("FAIL R6 %s top bit got %b expected %b", nm, cw[nn-1], e7);
                end
            end
        end else if (vld) begin
            checks++;
            errors++;
            $display("FAIL R2 %s cycle %0d valid got 1 expected 0", nm, cyc);
        end
    endtask

    // Monitor: pops the scoreboard as results appear.
    always @(negedge clk) begin
        if (!rst) begin
            chk(q16, ov16, cw16, 4, 8, "n16");
            chk(q8, ov8, {8'h00, cw8}, 3, 4, "n8");
        end
    end

    task automatic check_reset_state(input string when);
        checks++;
        if (ov16 !== 1'b0 || cw16 !== 16'h0000 || ov8 !== 1'b0 || cw8 !== 8'h00) begin
            errors++;
            $display("FAIL R1 %s got v16=%b cw16=%h v8=%b cw8=%h expected all 0",
                     when, ov16, cw16, ov8, cw8);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("initial reset");         // R1
        rst = 1'b0;
        idle(2);

        // R3: information bits at the top, at the bottom, and interleaved.
        send16(16'h00A5, 16'h00FF, "R3");
        send16(16'h005A, 16'hFF00, "R3");
        send16(16'h00FF, 16'h5555, "R3");
        send16(16'h0001, 16'hAAAA, "R3");
        send16(16'h0080, 16'h0F0F, "R3");
        send16(16'h0000, 16'h3C3C, "R3");
        idle(6);
        send8(16'h0009, 16'h000F, "R8");
        send8(16'h0006, 16'h00F0, "R8");
        send8(16'h000F, 16'h0055, "R8");
        send8(16'h0008, 16'h00AA, "R8");
        idle(6);

        // R4: one-hot messages reveal single generator rows.
        for (int j = 0; j < 8; j++) send16(16'h0001 << j, 16'h00FF, "R4");
        idle(6);

        // R7 / R2: back-to-back blocks, each with a new random mask.
        for (int j = 0; j < 150; j++) begin
            send16({8'h00, 8'($urandom)}, rand_mask(4, 8), "R7");
        end
        idle(6);
        for (int j = 0; j < 150; j++) begin
            send8({12'h000, 4'($urandom)}, rand_mask(3, 4), "R8");
        end
        idle(6);

        // R4: random traffic with gaps.
        for (int j = 0; j < 100; j++) begin
            send16({8'h00, 8'($urandom)}, rand_mask(4, 8), "R4");
            if (($urandom % 3) == 0) idle(int'($urandom % 4) + 1);
        end
        idle(6);

        // R1: reset with both pipelines full.
        for (int j = 0; j < 4; j++) begin
            fork
                send16({8'h00, 8'($urandom)}, rand_mask(4, 8), "R4");
                send8({12'h000, 4'($urandom)}, rand_mask(3, 4), "R8");
            join
        end
        @(negedge clk);
        rst = 1'b1; v16 = 1'b0; v8 = 1'b0;
        q16.delete();
        q8.delete();
        @(negedge clk);
        check_reset_state("mid-stream reset");      // R1
        rst = 1'b0;
        idle(8);                                     // R2: nothing drains after reset

        send16(16'h00C3, 16'hF00F, "R3");
        idle(8);
        summary();
    end

endmodule